// File: doc/BRIEF.md
# Filtered Edge-Select Input Capture Channel

This block is one capture channel that watches a single external digital input and records the value of a free-running timebase count when a qualifying edge arrives. The input is first brought into the clock domain by a two-stage synchroniser. A digital filter then accepts a change only after a programmable number of consecutive agreeing samples. An edge detector with selectable direction follows, and after it an event prescaler that lets only every 1st, 2nd, 4th or 8th accepted edge through.

On a qualifying edge the count is written into an internal shadow register. One cycle later it is copied into the software-visible capture register, and the capture flag is set. An interrupt request follows the flag when the interrupt enable is set. If a capture lands while the flag is still set, an overcapture flag records that a value was lost.

Software uses the channel for period or pulse-width measurement by flipping the edge direction between captures. It reaches the channel through a small word-addressed register port. Word 0 holds the configuration, word 1 the captured count, and word 2 the status flags.

Top module: `capture_channel`

## Requirements
- R1: After reset the configuration word, capture word and status word all read 0 and `irqOut` is low.
- R2: Config bits [3:2] pick the edge: 00 captures on rising edges, 01 on falling edges, and 10 or 11 on both edges.
- R3: Config bits [9:6] set the filter: 0000 accepts every sample, 0001 needs 2, 0010 needs 4 and any other code needs 8 consecutive equal synchronised samples before the filtered level changes. A shorter pulse is dropped.
- R4: Let an input change be first sampled at clock edge k, with N the filter length. The capture word then holds the count presented at edge k+N+2, and it reads back, with the flag set, after edge k+N+3.
- R5: Config bits [5:4] set the event prescaler: 00, 01, 10 and 11 capture on every 1st, 2nd, 4th and 8th edge of the selected direction, counted from the moment the channel is enabled.
- R6: Config bit 0 enables the channel. While it is 0, no edge captures, the capture word and status stay unchanged, and the prescaler count is cleared.
- R7: Config bits [9:2] take a write only while bit 0 currently reads 0. Bits 0 and 1 take every write.
- R8: Status bit 0 is the capture flag, set by each capture. Writing a 0 to a status bit clears it and writing a 1 leaves it. A set in the same cycle as a clear wins.
- R9: Status bit 1 is the overcapture flag, set when a capture arrives while status bit 0 is already 1.
- R10: `irqOut` is high exactly when status bit 0 is 1 and config bit 1 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| timeCount | input | CNT_W | Running timebase count to be captured |
| capIn | input | 1 | Asynchronous signal under measurement |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Word address for the write and for the read |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Interrupt request |

## Verification
The channel is driven with clean level sequences whose hold times exceed the longest filter, under randomly drawn edge, filter and prescaler settings. This separates the direction decode, the prescaler phase and the filter latency in the captured value. Short pulses one sample under the filter length show that the filter drops them rather than delaying them. Back-to-back captures without a clear, and config writes while the channel is enabled, tell the overcapture and lock logic apart from plain capture. A long disabled stretch checks that edges leave no trace and that the prescaler restarts cleanly.

// File: rtl/capture_pkg.sv
package capture_pkg;

  localparam logic [1:0] ADDR_CFG    = 2'd0;
  localparam logic [1:0] ADDR_VALUE  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int CFG_W = 10;

  // configuration word, msb first: filt[9:6] psc[5:4] pol[3:2] irqEn[1] en[0]
  typedef struct packed {
    logic [3:0] filt;
    logic [1:0] psc;
    logic [1:0] pol;
    logic       irqEn;
    logic       en;
  } cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shadowLoad;
    logic copyLoad;
  } capStrobe_t;

  function automatic logic [3:0] filtLenOf(input logic [3:0] code);
    case (code)
      4'd0:    filtLenOf = 4'd1;
      4'd1:    filtLenOf = 4'd2;
      4'd2:    filtLenOf = 4'd4;
      default: filtLenOf = 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] pscDivOf(input logic [1:0] code);
    pscDivOf = 4'd1 << code;
  endfunction

endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capIn,
  input  cfg_t       cfg,
  output capStrobe_t stb
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic       syncLvl;
  logic       filtLvl;
  logic       filtPrev;
  logic [2:0] filtCnt;
  logic [2:0] pscCnt;
  logic [3:0] filtLen;
  logic [3:0] pscDiv;
  logic       riseEv;
  logic       fallEv;
  logic       edgeHit;
  logic       fire;
  logic       copyQ;

  assign syncLvl = syncQ[SYNC_STAGES-1];
  assign filtLen = filtLenOf(cfg.filt);
  assign pscDiv  = pscDivOf(cfg.psc);

  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= capIn;
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], capIn};
      end
    end
  endgenerate

  // digital filter: level moves after filtLen agreeing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl <= 1'b0;
      filtCnt <= '0;
    end else if (syncLvl == filtLvl) begin
      filtCnt <= '0;
    end else if ({1'b0, filtCnt} == filtLen - 4'd1) begin
      filtLvl <= syncLvl;
      filtCnt <= '0;
    end else begin
      filtCnt <= filtCnt + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) filtPrev <= 1'b0;
    else       filtPrev <= filtLvl;
  end

  assign riseEv = filtLvl & ~filtPrev;
  assign fallEv = ~filtLvl & filtPrev;

  always_comb begin
    if (cfg.pol[1])      edgeHit = riseEv | fallEv;
    else if (cfg.pol[0]) edgeHit = fallEv;
    else                 edgeHit = riseEv;
  end

  assign fire = cfg.en & edgeHit & ({1'b0, pscCnt} == pscDiv - 4'd1);

  // event prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pscCnt <= '0;
    else if (!cfg.en)           pscCnt <= '0;
    else if (fire)              pscCnt <= '0;
    else if (edgeHit)           pscCnt <= pscCnt + 3'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) copyQ <= 1'b0;
    else       copyQ <= fire;
  end

  assign stb.shadowLoad = fire;
  assign stb.copyLoad   = copyQ;

endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import capture_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timeCount,
  input  capStrobe_t        stb,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output cfg_t              cfgQ,
  output logic [CNT_W-1:0]  capVal,
  output logic              capFlag,
  output logic              overFlag
);

  logic [CNT_W-1:0] shadowQ;
  cfg_t             cfgIn;
  logic             wrCfg;
  logic             wrStatus;
  logic             clrFlag;
  logic             clrOver;

  assign cfgIn    = cfg_t'(regWdata[CFG_W-1:0]);
  assign wrCfg    = regWrEn && (regAddr == ADDR_CFG);
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);
  assign clrFlag  = wrStatus && !regWdata[0];
  assign clrOver  = wrStatus && !regWdata[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrCfg) begin
      if (cfgQ.en) begin
        cfgQ.en    <= cfgIn.en;
        cfgQ.irqEn <= cfgIn.irqEn;
      end else begin
        cfgQ <= cfgIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowQ <= '0;
      capVal  <= '0;
    end else begin
      if (stb.shadowLoad) shadowQ <= timeCount;
      if (stb.copyLoad)   capVal  <= shadowQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFlag  <= 1'b0;
      overFlag <= 1'b0;
    end else begin
      if (stb.copyLoad)  capFlag <= 1'b1;
      else if (clrFlag)  capFlag <= 1'b0;
      if (stb.copyLoad && capFlag) overFlag <= 1'b1;
      else if (clrOver)            overFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CFG:    regRdata[CFG_W-1:0] = cfgQ;
      ADDR_VALUE:  regRdata[CNT_W-1:0] = capVal;
      ADDR_STATUS: regRdata[1:0]       = {overFlag, capFlag};
      default:     regRdata = '0;
    endcase
  end

endmodule

// File: rtl/capture_channel.sv
module capture_channel
  import capture_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  timeCount,
  input  logic              capIn,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  cfg_t             cfgQ;
  capStrobe_t       stb;
  logic [CNT_W-1:0] capVal;
  logic             capFlag;
  logic             overFlag;

  capture_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .capIn (capIn),
    .cfg   (cfgQ),
    .stb   (stb)
  );

  capture_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .timeCount (timeCount),
    .stb       (stb),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .cfgQ      (cfgQ),
    .capVal    (capVal),
    .capFlag   (capFlag),
    .overFlag  (overFlag)
  );

  assign irqOut = capFlag & cfgQ.irqEn;

endmodule

// File: rtl/capture_channel_chk.sv
module capture_channel_chk
  import capture_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input cfg_t             cfgQ,
  input capStrobe_t       stb,
  input logic [CNT_W-1:0] timeCount,
  input logic [CNT_W-1:0] capVal,
  input logic             capFlag,
  input logic             overFlag
);

  AST_COPY_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyLoad |=> capFlag); // R8

  AST_OVERCAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.copyLoad && capFlag) |=> overFlag); // R9

  AST_DISABLED_NO_COPY: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ.en |=> !stb.copyLoad); // R6

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.en |=> ($stable(cfgQ.filt) && $stable(cfgQ.psc) && $stable(cfgQ.pol))); // R7

  AST_SHADOW_BEFORE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyLoad |-> $past(stb.shadowLoad)); // R4

  AST_VALUE_FROM_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    stb.copyLoad |=> (capVal == $past(timeCount, 2))); // R4

endmodule

bind capture_channel capture_channel_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgQ      (cfgQ),
  .stb       (stb),
  .timeCount (timeCount),
  .capVal    (capVal),
  .capFlag   (capFlag),
  .overFlag  (overFlag)
);

// File: tb/tb_capture_channel.sv
module tb_capture_channel;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [CNT_W-1:0]  tc = '0;
  logic              capIn = 1'b0;
  logic              regWrEn = 1'b0;
  logic [1:0]        regAddr = 2'd0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;
  logic curLvl = 1'b0;
  logic [CNT_W-1:0] lastCap = '0;
  logic [CNT_W-1:0] t0;
  logic [DATA_W-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tc <= tc + 16'd1;

  capture_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .timeCount(tc), .capIn(capIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic int filtLen(input int code);
    if (code == 0) return 1;
    if (code == 1) return 2;
    if (code == 2) return 4;
    return 8;
  endfunction

  function automatic int pscDiv(input int code);
    return 1 << code;
  endfunction

  function automatic bit polMatch(input int pol, input bit rising);
    if (pol >= 2) return 1'b1;
    if (pol == 1) return !rising;
    return rising;
  endfunction

  function automatic logic [DATA_W-1:0] cfgWord(input int filt, input int psc,
                                                input int pol, input bit irqEn, input bit en);
    return DATA_W'((filt << 6) | (psc << 4) | (pol << 2) | (int'(irqEn) << 1) | int'(en));
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [DATA_W-1:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drive a level at a falling clock edge, hold it for the given cycles
  task automatic driveLevel(input logic lvl, input int hold);
    @(negedge clk);
    capIn = lvl;
    t0 = tc;
    repeat (hold - 1) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int evCnt;
    int n;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd0, rd); check("R1 cfg", rd, '0);
    readReg(2'd1, rd); check("R1 value", rd, '0);
    readReg(2'd2, rd); check("R1 status", rd, '0);
    check("R1 irq", DATA_W'(irqOut), '0);

    // R6 disabled channel ignores edges
    driveLevel(1'b1, 12); driveLevel(1'b0, 12);
    readReg(2'd2, rd); check("R6 disabled status", rd, '0);
    readReg(2'd1, rd); check("R6 disabled value", rd, '0);

    // R4/R10 rising capture, no filter, irq on
    writeReg(2'd0, cfgWord(0, 0, 0, 1'b1, 1'b1));
    driveLevel(1'b1, 12);
    readReg(2'd1, rd); check("R4 value", rd, DATA_W'(t0 + 16'd3));
    readReg(2'd2, rd); check("R8 flag", rd, 32'd1);
    check("R10 irq high", DATA_W'(irqOut), 32'd1);
    lastCap = t0 + 16'd3;

    // R7 field write while enabled is ignored, en/irqEn still written
    writeReg(2'd0, cfgWord(3, 2, 1, 1'b0, 1'b1));
    readReg(2'd0, rd); check("R7 locked", rd, cfgWord(0, 0, 0, 1'b0, 1'b1));
    check("R10 irq masked", DATA_W'(irqOut), 32'd0);
    writeReg(2'd0, cfgWord(0, 0, 0, 1'b1, 1'b1));

    // R9 overcapture: second capture without clearing
    driveLevel(1'b0, 12);
    driveLevel(1'b1, 12);
    readReg(2'd1, rd); check("R9 second value", rd, DATA_W'(t0 + 16'd3));
    readReg(2'd2, rd); check("R9 overcapture", rd, 32'd3);
    // R8 write 1 keeps, write 0 clears
    writeReg(2'd2, 32'd3);
    readReg(2'd2, rd); check("R8 write one keeps", rd, 32'd3);
    writeReg(2'd2, 32'd0);
    readReg(2'd2, rd); check("R8 cleared", rd, 32'd0);
    check("R10 irq low", DATA_W'(irqOut), 32'd0);

    // R3 filter 8 samples: 7-cycle pulse dropped, 8-cycle pulse accepted
    writeReg(2'd0, 32'd0);
    driveLevel(1'b0, 12);
    writeReg(2'd0, cfgWord(3, 0, 0, 1'b0, 1'b1));
    driveLevel(1'b1, 7);
    driveLevel(1'b0, 14);
    readReg(2'd2, rd); check("R3 glitch dropped", rd, 32'd0);
    driveLevel(1'b1, 8);
    lastCap = t0 + 16'd10;
    driveLevel(1'b0, 14);
    readReg(2'd1, rd); check("R3 filtered value", rd, DATA_W'(lastCap));
    readReg(2'd2, rd); check("R3 filtered flag", rd, 32'd1);
    writeReg(2'd2, 32'd0);
    curLvl = 1'b0;

    // random configurations, R2 R3 R4 R5
    for (int cfgIdx = 0; cfgIdx < 12; cfgIdx++) begin
      int filt, psc, pol;
      filt = int'($urandom_range(0, 5));
      psc  = int'($urandom_range(0, 3));
      pol  = int'($urandom_range(0, 3));
      n = filtLen(filt);
      writeReg(2'd0, 32'd0);
      writeReg(2'd0, cfgWord(filt, psc, pol, 1'b0, 1'b1));
      evCnt = 0;
      for (int lv = 0; lv < 14; lv++) begin
        logic nl;
        bit capt;
        nl = ~curLvl;
        driveLevel(nl, int'($urandom_range(13, 20)));
        curLvl = nl;
        capt = 1'b0;
        if (polMatch(pol, nl == 1'b1)) begin
          evCnt++;
          if (evCnt == pscDiv(psc)) begin
            evCnt = 0;
            capt = 1'b1;
            lastCap = t0 + CNT_W'(n + 2);
          end
        end
        readReg(2'd1, rd);
        check(capt ? "R4 R5 random value" : "R2 R5 random held value", rd, DATA_W'(lastCap));
        readReg(2'd2, rd);
        check(capt ? "R2 R5 random flag set" : "R2 R5 random no flag", rd, capt ? 32'd1 : 32'd0);
        if (capt) writeReg(2'd2, 32'd0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule